// File: doc/BRIEF.md
# Snooping Set-Associative Instruction Cache

This block is a read-only instruction cache placed between a processor fetch port and a slower memory port. It holds sixteen sets of four ways, and each line carries eight 32-bit words (32 bytes). A fetch that finds its line returns the word combinationally in the cycle it is presented. A fetch that misses stalls while the whole line is read from memory in eight ascending word beats, then the requested word is returned. The line goes into the least recently used way of its set.

A separate snoop port reports writes made by other bus masters. Any cached line that holds a written address is invalidated, so the next fetch reads it again from memory. If the line being filled is written during the fill, it is left invalid when the fill ends, and the requested word is still returned once. Fetches flagged as uncacheable, and all fetches made while the enable input is low, go to memory as one single-word read that neither looks up nor allocates. A one-cycle flush input invalidates every line.

Top module: `ifetch_cache`

## Requirements
- R1: A cacheable fetch, made with the cache enabled, whose line is valid in the set selected by address bits [8:5] under tag bits [31:9] raises rsp_valid in the same cycle. The word returned is the one at word select bits [4:2], and no memory beat is issued.
- R2: A cacheable fetch that misses issues exactly eight memory beats at the line base plus 4·k for k = 0..7 in ascending order. It holds mem_addr steady while mem_ready is low, and returns the requested word one cycle after the last beat. A second fetch to the same line then hits.
- R3: The victim of a miss is the least recently used way of its set. Recency is updated on every hit and on every fill. After reset the order from most to least recent is way 0, 1, 2, 3.
- R4: A snoop write to an address whose line is cached invalidates that line from the next clock edge, so the next fetch to it misses.
- R5: A snoop write to the line being filled still lets the fetch return its word exactly once. The line is left invalid at the end of the fill.
- R6: A fetch with fetch_uncached high issues one memory beat at the exact fetch address, returns that word, and allocates nothing. Repeated uncached fetches each reach memory, and a later cacheable fetch of that line misses.
- R7: While cache_en is low, every fetch issues one memory beat at the fetch address and changes neither line contents nor recency. A line cached before is still a hit once cache_en returns high.
- R8: A one-cycle pulse on flush_all invalidates every line, so each following cacheable fetch misses.
- R9: During and right after reset, rsp_valid and mem_valid are low and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | High enables lookup and allocation |
| flush_all | input | 1 | One-cycle pulse invalidates every line |
| fetch_req | input | 1 | Fetch request, held until rsp_valid |
| fetch_addr | input | 32 | Fetch byte address, word aligned |
| fetch_uncached | input | 1 | Fetch targets an uncacheable region |
| rsp_valid | output | 1 | Fetch response word is valid this cycle |
| rsp_data | output | 32 | Fetch response word |
| mem_valid | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read word address |
| mem_ready | input | 1 | Memory accepts the read and returns data this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| snp_valid | input | 1 | Observed bus write |
| snp_addr | input | 32 | Address of the observed bus write |

## Verification
The assertions assume the requester holds fetch_req, fetch_addr and fetch_uncached steady from the cycle the request is raised until rsp_valid is seen, and that a snoop is not presented in the same cycle as a hit it would affect. The stimulus changes inputs only on falling edges and opens a new fetch only after the previous response edge. Snoops and flushes are issued between fetches, except in the directed case that writes to the line while it is being filled. Memory readiness is drawn at random each cycle, so fills stretch over a varying number of cycles.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FILL   = 2'd1,
      ST_BYPASS = 2'd2,
      ST_RESP   = 2'd3
   } ifc_state_e;
endpackage

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int TAG_W = 23
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [$clog2(SETS)-1:0]     lk_set,
   input  logic [TAG_W-1:0]            lk_tag,
   output logic [WAYS-1:0]             hit_vec,
   input  logic                        wr_en,
   input  logic [$clog2(SETS)-1:0]     wr_set,
   input  logic [$clog2(WAYS)-1:0]     wr_way,
   input  logic [TAG_W-1:0]            wr_tag,
   input  logic                        wr_valid,
   input  logic                        snp_en,
   input  logic [$clog2(SETS)-1:0]     snp_set,
   input  logic [TAG_W-1:0]            snp_tag,
   input  logic                        flush_all
);
   localparam int IDX_W = $clog2(SETS);

   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [WAYS-1:0]  valid_q [SETS];

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
   end

   // valid bits: flush beats snoop, fill write beats snoop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else if (flush_all) begin
         for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else begin
         if (snp_en) begin
            for (int w = 0; w < WAYS; w++) begin
               if (valid_q[snp_set][w] && (tag_q[snp_set][w] == snp_tag))
                  valid_q[snp_set][w] <= 1'b0;
            end
         end
         if (wr_en) valid_q[wr_set][wr_way] <= wr_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
   end

   // ---- checks ----
   logic             chk_q;
   logic [IDX_W-1:0] chk_set_q;
   logic [TAG_W-1:0] chk_tag_q;
   logic [WAYS-1:0]  left_vec;
   logic             any_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_q     <= 1'b0;
         chk_set_q <= '0;
         chk_tag_q <= '0;
      end else begin
         chk_q     <= snp_en && !(wr_en && wr_valid && (wr_set == snp_set) && (wr_tag == snp_tag));
         chk_set_q <= snp_set;
         chk_tag_q <= snp_tag;
      end
   end

   always_comb begin
      any_valid = 1'b0;
      for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
      for (int w = 0; w < WAYS; w++)
         left_vec[w] = valid_q[chk_set_q][w] && (tag_q[chk_set_q][w] == chk_tag_q);
   end

   assert_snoop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chk_q |-> (left_vec == '0));

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !any_valid);
endmodule

// File: rtl/ifc_lru.sv
module ifc_lru #(
   parameter int SETS = 16,
   parameter int WAYS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(SETS)-1:0] rd_set,
   output logic [$clog2(WAYS)-1:0] victim_way,
   input  logic                    touch_en,
   input  logic [$clog2(SETS)-1:0] touch_set,
   input  logic [$clog2(WAYS)-1:0] touch_way
);
   localparam int WAY_W = $clog2(WAYS);
   localparam int AGE_W = WAY_W;

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("ifc_lru: WAYS must be a power of two of at least 2");
   end

   // age 0 = most recent, WAYS-1 = least recent; ages in a set form a permutation
   logic [AGE_W-1:0] age_q [SETS][WAYS];
   logic [WAYS-1:0]  victim_oh;

   always_comb begin
      victim_way = '0;
      victim_oh  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (age_q[rd_set][w] == AGE_W'(WAYS - 1)) begin
            victim_way   = WAY_W'(w);
            victim_oh[w] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= AGE_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[touch_set][w] <= '0;
            else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
               age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
         end
      end
   end

   assert_victim_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(victim_oh) == 1);
endmodule

// File: rtl/ifc_data_store.sv
module ifc_data_store #(
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   parameter int WORDS  = 8,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic [$clog2(SETS)-1:0]  rd_set,
   input  logic [$clog2(WAYS)-1:0]  rd_way,
   input  logic [$clog2(WORDS)-1:0] rd_word,
   output logic [DATA_W-1:0]        rd_data,
   input  logic                     we,
   input  logic [$clog2(SETS)-1:0]  wr_set,
   input  logic [$clog2(WAYS)-1:0]  wr_way,
   input  logic [$clog2(WORDS)-1:0] wr_word,
   input  logic [DATA_W-1:0]        wr_data
);
   localparam int DEPTH = SETS * WAYS * WORDS;
   localparam int A_W   = $clog2(DEPTH);

   if ((1 << A_W) != DEPTH) begin : g_bad_depth
      $error("ifc_data_store: SETS, WAYS and WORDS must be powers of two");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [A_W-1:0]    rd_idx, wr_idx;

   assign rd_idx  = {rd_set, rd_way, rd_word};
   assign wr_idx  = {wr_set, wr_way, wr_word};
   assign rd_data = mem_q[rd_idx];

   always_ff @(posedge clk) begin
      if (we) mem_q[wr_idx] <= wr_data;
   end
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
   import ifc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SETS       = 16,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cache_en,
   input  logic              flush_all,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_uncached,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr
);
   localparam int BYTES  = DATA_W / 8;
   localparam int WORDS  = LINE_BYTES / BYTES;
   localparam int BYTE_W = $clog2(BYTES);
   localparam int WSEL_W = $clog2(WORDS);
   localparam int OFF_W  = BYTE_W + WSEL_W;
   localparam int IDX_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int LINE_W = ADDR_W - OFF_W;

   if (DATA_W % 8 != 0 || (1 << BYTE_W) != BYTES) begin : g_bad_data
      $error("ifetch_cache: DATA_W must be a power-of-two number of bytes");
   end
   if (WORDS < 2 || (1 << WSEL_W) != WORDS) begin : g_bad_line
      $error("ifetch_cache: LINE_BYTES must hold a power-of-two number of words");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ifetch_cache: address too narrow for the geometry");
   end

   ifc_state_e        state_q;
   logic [LINE_W-1:0] line_q;
   logic [WSEL_W-1:0] word_q, cnt_q;
   logic [WAY_W-1:0]  victim_q;
   logic              killed_q;
   logic [DATA_W-1:0] hold_q;
   logic [ADDR_W-1:0] byp_addr_q;

   logic [IDX_W-1:0]  lk_set;
   logic [TAG_W-1:0]  lk_tag;
   logic [WSEL_W-1:0] lk_word;
   logic [WAYS-1:0]   hit_vec;
   logic [WAY_W-1:0]  hit_way, lru_victim;
   logic              cacheable, lookup_hit;
   logic [DATA_W-1:0] rd_data;
   logic              last_beat, fill_beat, fill_hit_snoop;
   logic              tag_we, tag_wv;
   logic              touch_en;
   logic [IDX_W-1:0]  touch_set;
   logic [WAY_W-1:0]  touch_way;

   assign lk_set  = fetch_addr[OFF_W +: IDX_W];
   assign lk_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
   assign lk_word = fetch_addr[BYTE_W +: WSEL_W];

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end

   assign cacheable      = cache_en && !fetch_uncached;
   assign lookup_hit     = (state_q == ST_IDLE) && fetch_req && cacheable && (|hit_vec);
   assign last_beat      = (cnt_q == WSEL_W'(WORDS - 1));
   assign fill_beat      = (state_q == ST_FILL) && mem_ready;
   assign fill_hit_snoop = snp_valid && (snp_addr[ADDR_W-1:OFF_W] == line_q);
   assign tag_we         = fill_beat && last_beat;
   assign tag_wv         = !(killed_q || fill_hit_snoop || flush_all);

   assign touch_en  = lookup_hit || tag_we;
   assign touch_set = tag_we ? line_q[IDX_W-1:0] : lk_set;
   assign touch_way = tag_we ? victim_q : hit_way;

   assign rsp_valid = lookup_hit || (state_q == ST_RESP);
   assign rsp_data  = (state_q == ST_RESP) ? hold_q : rd_data;
   assign mem_valid = (state_q == ST_FILL) || (state_q == ST_BYPASS);
   assign mem_addr  = (state_q == ST_FILL) ? {line_q, cnt_q, {BYTE_W{1'b0}}} : byp_addr_q;

   ifc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_set    (lk_set),
      .lk_tag    (lk_tag),
      .hit_vec   (hit_vec),
      .wr_en     (tag_we),
      .wr_set    (line_q[IDX_W-1:0]),
      .wr_way    (victim_q),
      .wr_tag    (line_q[LINE_W-1:IDX_W]),
      .wr_valid  (tag_wv),
      .snp_en    (snp_valid),
      .snp_set   (snp_addr[OFF_W +: IDX_W]),
      .snp_tag   (snp_addr[ADDR_W-1 -: TAG_W]),
      .flush_all (flush_all)
   );

   ifc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_set     (lk_set),
      .victim_way (lru_victim),
      .touch_en   (touch_en),
      .touch_set  (touch_set),
      .touch_way  (touch_way)
   );

   ifc_data_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .rd_set  (lk_set),
      .rd_way  (hit_way),
      .rd_word (lk_word),
      .rd_data (rd_data),
      .we      (fill_beat),
      .wr_set  (line_q[IDX_W-1:0]),
      .wr_way  (victim_q),
      .wr_word (cnt_q),
      .wr_data (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         line_q     <= '0;
         word_q     <= '0;
         cnt_q      <= '0;
         victim_q   <= '0;
         killed_q   <= 1'b0;
         hold_q     <= '0;
         byp_addr_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (fetch_req && !lookup_hit) begin
                  if (cacheable) begin
                     state_q  <= ST_FILL;
                     line_q   <= fetch_addr[ADDR_W-1:OFF_W];
                     word_q   <= lk_word;
                     cnt_q    <= '0;
                     victim_q <= lru_victim;
                     killed_q <= 1'b0;
                  end else begin
                     state_q    <= ST_BYPASS;
                     byp_addr_q <= fetch_addr;
                  end
               end
            end
            ST_FILL: begin
               if (fill_hit_snoop || flush_all) killed_q <= 1'b1;
               if (mem_ready) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == word_q) hold_q <= mem_rdata;
                  if (last_beat) state_q <= ST_RESP;
               end
            end
            ST_BYPASS: begin
               if (mem_ready) begin
                  hold_q  <= mem_rdata;
                  state_q <= ST_RESP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---- checks ----
   assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

   assert_rsp_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RESP) |=> (state_q == ST_IDLE));

   assert_bypass_no_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BYPASS) |-> !tag_we);

   assert_disabled_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cache_en && (state_q == ST_IDLE) |-> !rsp_valid);

   assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !mem_valid);
endmodule

// File: tb/ifetch_cache_tb.sv
`timescale 1ns/1ps
module ifetch_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cache_en = 1'b1, flush_all = 1'b0;
   logic        fetch_req = 1'b0, fetch_uncached = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        rsp_valid, mem_valid;
   logic [31:0] rsp_data, mem_addr, mem_rdata;
   logic        mem_ready = 1'b0;
   logic        snp_valid = 1'b0;
   logic [31:0] snp_addr = '0;

   always #10 clk = ~clk;   // 50 MHz

   ifetch_cache u_dut (
      .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush_all(flush_all),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_uncached(fetch_uncached),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .snp_valid(snp_valid), .snp_addr(snp_addr)
   );

   int          checks = 0, fails = 0;
   int          beats = 0;
   logic [31:0] beat_addr [16];
   bit          rdy_always = 1'b0;
   bit          fill_killed = 1'b0;
   int          ver [128];
   logic [22:0] m_tag [16][4];
   bit          m_val [16][4];
   int          m_age [16][4];

   function automatic logic [31:0] memword(logic [31:0] a, int v);
      return {a[31:2], 2'b11} ^ (32'(v) << 16) ^ 32'h9E37_0000;
   endfunction

   always_comb mem_rdata = memword(mem_addr, ver[mem_addr[11:5]]);

   always @(negedge clk) mem_ready <= rdy_always ? 1'b1 : (($urandom % 4) != 0);

   always @(negedge clk) begin
      #2;
      if (mem_valid && mem_ready) begin
         beat_addr[beats & 15] = mem_addr;
         beats++;
      end
   end

   task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic touch(int s, int way);
      int a0 = m_age[s][way];
      for (int w = 0; w < 4; w++) begin
         if (w == way) m_age[s][w] = 0;
         else if (m_age[s][w] < a0) m_age[s][w]++;
      end
   endtask

   task automatic do_fetch(logic [31:0] a, bit unc, string tag_in);
      int          s = int'(a[8:5]);
      logic [22:0] tg = a[31:9];
      bit          cach = cache_en && !unc;
      int          hw = -1;
      int          exp_beats;
      logic [31:0] exp_data, got;
      string       rq;
      bit          ok;
      int          way;
      for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == tg) hw = w;
      exp_data  = memword(a, ver[a[11:5]]);
      exp_beats = !cach ? 1 : (hw >= 0 ? 0 : 8);
      if (!cache_en) rq = "R7";
      else if (unc) rq = "R6";
      else if (hw >= 0) rq = "R1";
      else rq = "R2";
      rq = {rq, " ", tag_in};
      beats = 0;
      fetch_addr = a; fetch_uncached = unc; fetch_req = 1'b1;
      #1;
      while (!rsp_valid) begin @(negedge clk); #1; end
      got = rsp_data;
      @(posedge clk);
      @(negedge clk);
      fetch_req = 1'b0;
      chk(got == exp_data, rq, "data", got, exp_data);
      chk(beats == exp_beats, rq, "beats", 32'(beats), 32'(exp_beats));
      if (exp_beats == 8) begin
         ok = 1'b1;
         for (int k = 0; k < 8; k++)
            if (beat_addr[k] != {a[31:5], 3'(k), 2'b00}) ok = 1'b0;
         chk(ok, "R2", "fill order", beat_addr[7], {a[31:5], 5'b11100});
      end
      if (exp_beats == 1) chk(beat_addr[0] == a, rq, "single beat addr", beat_addr[0], a);
      if (cach) begin
         if (hw >= 0) way = hw;
         else begin
            way = 0;
            for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) way = w;
            m_tag[s][way] = tg;
            m_val[s][way] = !fill_killed;
         end
         touch(s, way);
      end
   endtask

   task automatic do_snoop(logic [31:0] a);
      int s = int'(a[8:5]);
      snp_addr = a; snp_valid = 1'b1;
      ver[a[11:5]]++;
      for (int w = 0; w < 4; w++) if (m_tag[s][w] == a[31:9]) m_val[s][w] = 1'b0;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   task automatic do_flush();
      flush_all = 1'b1;
      for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) m_val[s][w] = 1'b0;
      @(negedge clk);
      flush_all = 1'b0;
   endtask

   function automatic logic [31:0] mk(int tg, int s, int wd);
      return (32'(tg) << 9) | (32'(s) << 5) | (32'(wd) << 2);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h1C4E));
      for (int i = 0; i < 128; i++) ver[i] = 0;
      for (int s = 0; s < 16; s++)
         for (int w = 0; w < 4; w++) begin
            m_val[s][w] = 1'b0; m_tag[s][w] = '0; m_age[s][w] = w;
         end
      repeat (3) @(negedge clk);
      chk(!rsp_valid && !mem_valid, "R9", "outputs in reset", {30'b0, rsp_valid, mem_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rsp_valid && !mem_valid, "R9", "outputs after reset", {30'b0, rsp_valid, mem_valid}, 32'h0);

      // basic miss then hits
      do_fetch(mk(0, 2, 1), 1'b0, "R9 first fetch misses");
      do_fetch(mk(0, 2, 1), 1'b0, "repeat");
      do_fetch(mk(0, 2, 7), 1'b0, "other word");
      // LRU replacement in set 2
      do_fetch(mk(1, 2, 0), 1'b0, "R3 fill");
      do_fetch(mk(2, 2, 3), 1'b0, "R3 fill");
      do_fetch(mk(3, 2, 5), 1'b0, "R3 fill");
      do_fetch(mk(0, 2, 2), 1'b0, "R3 refresh");
      do_fetch(mk(4, 2, 4), 1'b0, "R3 evict");
      do_fetch(mk(0, 2, 0), 1'b0, "R3 survivor");
      do_fetch(mk(1, 2, 0), 1'b0, "R3 evicted");
      // snoop invalidation
      do_snoop(mk(0, 2, 6));
      do_fetch(mk(0, 2, 0), 1'b0, "R4 after snoop");
      // snoop during fill
      rdy_always = 1'b1;
      fill_killed = 1'b1;
      fork
         do_fetch(mk(5, 9, 0), 1'b0, "R5 fill hit by snoop");
         begin repeat (3) @(negedge clk); do_snoop(mk(5, 9, 4)); end
      join
      fill_killed = 1'b0;
      rdy_always = 1'b0;
      do_fetch(mk(5, 9, 0), 1'b0, "R5 line left invalid");
      // uncached
      do_fetch(mk(0, 2, 0), 1'b1, "cached line");
      do_fetch(mk(3, 11, 2), 1'b1, "first");
      do_fetch(mk(3, 11, 2), 1'b1, "again");
      do_fetch(mk(3, 11, 2), 1'b0, "R6 no allocation");
      // disabled
      cache_en = 1'b0;
      do_fetch(mk(3, 11, 2), 1'b0, "disabled");
      do_fetch(mk(2, 6, 2), 1'b0, "disabled new line");
      cache_en = 1'b1;
      do_fetch(mk(3, 11, 2), 1'b0, "R7 kept after enable");
      do_fetch(mk(2, 6, 2), 1'b0, "R7 not allocated");
      // flush
      do_flush();
      do_fetch(mk(3, 11, 2), 1'b0, "R8 after flush");
      do_fetch(mk(0, 2, 0), 1'b0, "R8 after flush");

      // constrained random
      for (int i = 0; i < 400; i++) begin
         int          op = int'($urandom % 20);
         logic [31:0] a = mk(int'($urandom % 6), int'($urandom % 16), int'($urandom % 8));
         if (op < 13)       do_fetch(a, 1'b0, "random");
         else if (op < 15)  do_fetch(a, 1'b1, "random");
         else if (op < 17) begin do_snoop(a); do_fetch(a, 1'b0, "R4 random"); end
         else if (op == 17) do_flush();
         else if (op == 18) begin cache_en = 1'b0; do_fetch(a, 1'b0, "random"); cache_en = 1'b1; end
         else               do_snoop(a);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule